// File: doc/BRIEF.md
# FIFO-Fed I2C Master Transmitter

This block is the write-direction engine of an I2C controller in master mode. Firmware loads a byte queue with a slave address whose R/W bit is 0, followed by payload bytes. It then pulses a start input, and later raises a stop or restart request. The engine generates a START condition. It takes the first queued byte as the address and shifts every byte out most-significant bit first. After each byte it samples the slave's acknowledge. Bus timing comes from a divider: each SCL low phase and each SCL high phase lasts `DIV` system clocks.

The queue need not hold the whole message. When the queue is empty at a byte boundary, the engine parks with SCL held low and waits. It resumes when a byte arrives, or it ends the segment if a request is pending. When the queue has drained and a request is latched, the engine pulses a done flag. It then issues a STOP, or a repeated START followed by a fresh address phase. If the slave does not acknowledge, the engine flags the error, discards the queue and the pending requests, and releases the bus with a STOP.

The pins are open-drain. Each output is a pull-low enable: 1 pulls the line low and 0 releases it. The inputs carry the resolved line levels.

Top module: `i2c_fifo_tx`

## Requirements
- R1: The byte queue holds up to `DEPTH` (default 8) bytes in write order. `fifo_level` reports the count. `fifo_full` is 1 exactly when the count equals `DEPTH`. Firmware can therefore preload an address byte plus `DEPTH-1` payload bytes before starting.
- R2: A write while `fifo_full` is 1 is discarded and leaves `fifo_level` unchanged. In that case `fifo_ovf` is 1 for one cycle, in the cycle after the write's clock edge.
- R3: A `start` pulse while idle produces a START condition (SDA falls while SCL is high), followed by the first queued byte. A `start` pulse while `busy` is 1 has no effect.
- R4: Bytes go out MSB first, 8 data clocks and then 1 acknowledge clock. Every SCL high phase of a data or acknowledge clock lasts exactly `DIV` cycles. SDA changes while SCL is high only to form a START or a STOP.
- R5: The first byte after each START is the address. When the slave acknowledges it (SDA low on the 9th clock), `addr_ack` pulses once.
- R6: If the queue is empty at a byte boundary and no request is pending, the engine holds SCL low and produces no further clocks or conditions until data or a request appears.
- R7: While the engine is parked, a queued byte is taken at the first clock edge at which it is present. If a write lands on that same edge, `fifo_level` stays at 1, and both bytes are sent in write order.
- R8: A `stop_req` or `restart_req` pulse while busy is latched. It is acted on only once the queue is empty at a byte boundary. `done` then pulses once, and the engine issues a STOP or a repeated START respectively.
- R9: If both requests are latched at once, the STOP is issued and the restart is dropped.
- R10: After a repeated START, the next queued byte is again treated as an address and can pulse `addr_ack`.
- R11: A NACK on the address or on a data byte does four things: it pulses `nack_err`, empties the queue (`fifo_level` 0), clears the latched requests, and issues a STOP without `done`. A later transfer therefore parks until a new request arrives.
- R12: After reset both pins are released, `busy`, `fifo_level` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 8 | Byte to queue (address or payload) |
| start | input | 1 | Begin a transfer (used only when idle) |
| restart_req | input | 1 | Request a repeated START after the queue drains |
| stop_req | input | 1 | Request a STOP after the queue drains |
| sda_i | input | 1 | Resolved SDA line level |
| scl_i | input | 1 | Resolved SCL line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| fifo_full | output | 1 | Queue holds `DEPTH` bytes |
| fifo_level | output | $clog2(DEPTH+1) | Number of queued bytes |
| busy | output | 1 | Engine is not idle |
| addr_ack | output | 1 | One-cycle pulse: address byte acknowledged |
| done | output | 1 | One-cycle pulse: queue drained and request taken |
| nack_err | output | 1 | One-cycle pulse: slave did not acknowledge |
| fifo_ovf | output | 1 | One-cycle pulse: write to a full queue dropped |

## Verification
The queue's write port and the engine's pop can fall on the same clock edge. The bench provokes this by parking the engine on an empty queue and then writing on two consecutive cycles, so that the second write lands on the edge where the first byte is taken. A per-cycle model of the level, built from queue arithmetic, must read 1 after each of those edges. The decoded bus stream must then contain both bytes in write order. A second coincidence, a stop and a restart request raised in the same cycle, is judged by the decoded stream ending in a single STOP.

// File: rtl/i2c_fifo_tx.sv
module i2c_fifo_tx #(
  parameter int DIV   = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [7:0]                 wr_data,
  input  logic                       start,
  input  logic                       restart_req,
  input  logic                       stop_req,
  input  logic                       sda_i,
  input  logic                       scl_i,
  output logic                       sda_oe,
  output logic                       scl_oe,
  output logic                       fifo_full,
  output logic [$clog2(DEPTH+1)-1:0] fifo_level,
  output logic                       busy,
  output logic                       addr_ack,
  output logic                       done,
  output logic                       nack_err,
  output logic                       fifo_ovf
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_FETCH, S_BLO, S_BHI, S_ALO, S_AHI,
    S_PLO, S_PHI, S_PEND, S_RLO, S_RHI
  } st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [7:0]    sh;
  logic [2:0]    bitn;
  logic          is_addr, rq_rs, rq_sp, sda_q, sda_want;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] lvl;
  logic          empty, pop, flush, push, timed, go, tick, adv;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty      = (lvl == '0);
  assign fifo_full  = (lvl == LW'(DEPTH));
  assign fifo_level = lvl;
  assign busy       = (state != S_IDLE);
  assign timed      = (state != S_IDLE) && (state != S_FETCH);
  assign go         = scl_oe || scl_i;
  assign tick       = (cnt == CW'(DIV - 1));
  assign adv        = tick && go;
  assign pop        = (state == S_FETCH) && !empty;
  assign flush      = (state == S_AHI) && adv && sda_i;
  assign push       = wr_en && !fifo_full && !flush;
  assign sda_oe     = sda_q;

  always_comb begin
    case (state)
      S_FETCH, S_BLO, S_ALO, S_PLO, S_RLO: scl_oe = 1'b1;
      default:                             scl_oe = 1'b0;
    endcase
  end

  always_comb begin
    case (state)
      S_START, S_FETCH, S_PLO, S_PHI: sda_want = 1'b1;
      S_BLO, S_BHI:                   sda_want = ~sh[7];
      default:                        sda_want = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      lvl      <= '0;
      fifo_ovf <= 1'b0;
    end else begin
      fifo_ovf <= wr_en && fifo_full;
      if (flush) begin
        wp  <= '0;
        rp  <= '0;
        lvl <= '0;
      end else begin
        if (push) wp <= nxt(wp);
        if (pop)  rp <= nxt(rp);
        lvl <= lvl + LW'(push) - LW'(pop);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      sh       <= '0;
      bitn     <= '0;
      is_addr  <= 1'b0;
      rq_rs    <= 1'b0;
      rq_sp    <= 1'b0;
      sda_q    <= 1'b0;
      addr_ack <= 1'b0;
      done     <= 1'b0;
      nack_err <= 1'b0;
    end else begin
      addr_ack <= 1'b0;
      done     <= 1'b0;
      nack_err <= 1'b0;
      sda_q    <= sda_want;
      if (!timed)   cnt <= '0;
      else if (go)  cnt <= tick ? '0 : cnt + 1'b1;
      if (busy) begin
        if (restart_req) rq_rs <= 1'b1;
        if (stop_req)    rq_sp <= 1'b1;
      end
      case (state)
        S_IDLE: if (start) begin
          state   <= S_START;
          is_addr <= 1'b1;
        end
        S_START: if (adv) state <= S_FETCH;
        S_FETCH: begin
          if (!empty) begin
            sh    <= mem[rp];
            bitn  <= '0;
            state <= S_BLO;
          end else if (rq_sp) begin
            done  <= 1'b1;
            rq_sp <= 1'b0;
            rq_rs <= 1'b0;
            state <= S_PLO;
          end else if (rq_rs) begin
            done  <= 1'b1;
            rq_rs <= 1'b0;
            state <= S_RLO;
          end
        end
        S_BLO: if (adv) state <= S_BHI;
        S_BHI: if (adv) begin
          if (bitn == 3'd7) state <= S_ALO;
          else begin
            bitn  <= bitn + 1'b1;
            sh    <= {sh[6:0], 1'b0};
            state <= S_BLO;
          end
        end
        S_ALO: if (adv) state <= S_AHI;
        S_AHI: if (adv) begin
          if (sda_i) begin
            nack_err <= 1'b1;
            rq_rs    <= 1'b0;
            rq_sp    <= 1'b0;
            state    <= S_PLO;
          end else begin
            addr_ack <= is_addr;
            state    <= S_FETCH;
          end
          is_addr <= 1'b0;
        end
        S_PLO: if (adv) state <= S_PHI;
        S_PHI: if (adv) state <= S_PEND;
        S_PEND: if (adv) state <= S_IDLE;
        S_RLO: if (adv) state <= S_RHI;
        S_RHI: if (adv) begin
          state   <= S_START;
          is_addr <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LW'(DEPTH));

  assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_full && !pop && !flush) |=> (fifo_ovf && lvl == $past(lvl)));

  assert_sda_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && sda_oe != $past(sda_oe))
      |-> ($past(state) == S_START || $past(state) == S_PEND));

  assert_park_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH && empty && !rq_rs && !rq_sp) |=> scl_oe);

  assert_done_drained_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(lvl) == '0 && !nack_err));

  assert_nack_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    nack_err |-> (lvl == '0 && !rq_rs && !rq_sp && !done));
endmodule

// File: tb/i2c_fifo_tx_tb.sv
module i2c_fifo_tx_tb;
  localparam int DIV   = 4;
  localparam int DEPTH = 8;
  localparam int LW    = $clog2(DEPTH + 1);
  localparam int EV_START = 256;
  localparam int EV_STOP  = 257;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, start = 1'b0, rs_req = 1'b0, sp_req = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic sda_oe, scl_oe, fifo_full, busy, addr_ack, done, nack_err, fifo_ovf;
  logic [LW-1:0] fifo_level;
  logic sl_drv = 1'b0;
  logic sda_line, scl_line;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || sl_drv);

  always #10 clk = ~clk;

  i2c_fifo_tx #(.DIV(DIV), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .start(start), .restart_req(rs_req), .stop_req(sp_req),
    .sda_i(sda_line), .scl_i(scl_line), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .fifo_full(fifo_full), .fifo_level(fifo_level), .busy(busy),
    .addr_ack(addr_ack), .done(done), .nack_err(nack_err), .fifo_ovf(fifo_ovf));

  int nchk = 0, nfail = 0, cyc = 0;
  int ev[$];
  int exp_q[$];
  int n_adr = 0, n_done = 0, n_nack = 0, hbad = 0;
  int nack_pos = -1, bpos = 0, bitc = 0, hcnt = 0;
  bit pscl = 1'b1, psda = 1'b1, evh = 1'b1;
  logic [7:0] rx = 8'h00;
  int mdl_lvl = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic expb(input int v);
    exp_q.push_back(v);
  endtask

  task automatic chk_ev(input string req);
    bit ok = (ev.size() == exp_q.size());
    int bad = -1;
    if (ok) for (int i = 0; i < ev.size(); i++)
      if (ev[i] != exp_q[i] && bad < 0) begin bad = i; ok = 1'b0; end
    if (bad < 0) chk(ok, {req, " bus event count"}, ev.size(), exp_q.size());
    else chk(ok, {req, " bus event value"}, ev[bad], exp_q[bad]);
    ev.delete();
    exp_q.delete();
  endtask

  // Behavioural slave and bus decoder, sampled away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (addr_ack) n_adr++;
    if (done)     n_done++;
    if (nack_err) n_nack++;
    if (rst_n) begin
      if (scl_line && pscl) begin
        if (psda && !sda_line) begin ev.push_back(EV_START); bitc = 0; bpos = 0; evh = 1'b1; end
        if (!psda && sda_line) begin ev.push_back(EV_STOP);  bitc = 0; evh = 1'b1; end
        hcnt++;
      end else if (scl_line && !pscl) begin
        hcnt = 1;
        evh  = 1'b0;
        if (bitc < 8) begin rx = {rx[6:0], sda_line}; bitc++; end
        else begin ev.push_back(int'(rx)); bitc = 0; bpos++; end
      end else if (!scl_line && pscl) begin
        if (!evh && hcnt != DIV) hbad++;
        sl_drv = (bitc == 8) && (bpos != nack_pos);
      end
      pscl = scl_line;
      psda = sda_line;
    end
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  task automatic push(input logic [7:0] b, input bit model);
    bit ov;
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
    if (model) begin
      ov = (mdl_lvl == DEPTH);
      if (!ov) mdl_lvl++;
      chk(fifo_level == LW'(mdl_lvl), "R1 level after write", int'(fifo_level), mdl_lvl);
      chk(fifo_full == (mdl_lvl == DEPTH), "R1 full flag", int'(fifo_full), int'(mdl_lvl == DEPTH));
      chk(fifo_ovf == ov, "R2 overflow pulse", int'(fifo_ovf), int'(ov));
    end
  endtask

  task automatic ctl(input int which);
    @(negedge clk);
    if (which == 0) start = 1'b1;
    if (which == 1) rs_req = 1'b1;
    if (which == 2) sp_req = 1'b1;
    if (which == 3) begin rs_req = 1'b1; sp_req = 1'b1; end
    @(negedge clk);
    start = 1'b0; rs_req = 1'b0; sp_req = 1'b0;
  endtask

  task automatic idle_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    idle_wait(2 * DIV);
  endtask

  initial begin
    idle_wait(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy, "R12 pins released, idle", int'({scl_oe, sda_oe, busy}), 0);
    chk(fifo_level == '0 && !fifo_full, "R12 queue empty", int'(fifo_level), 0);
    chk(!addr_ack && !done && !nack_err && !fifo_ovf, "R12 flags low", int'({addr_ack, done, nack_err, fifo_ovf}), 0);

    // Preload: address plus DEPTH-1 payload bytes, then one write too many.
    mdl_lvl = 0;
    push(8'hA0, 1'b1);
    for (int i = 1; i < DEPTH; i++) push(8'(i), 1'b1);
    push(8'hEE, 1'b1);
    ctl(0);
    idle_wait(30);
    ctl(0);
    ctl(2);
    wait_idle();
    expb(EV_START); expb(8'hA0);
    for (int i = 1; i < DEPTH; i++) expb(i);
    expb(EV_STOP);
    chk_ev("R3 R8 preloaded transfer with stop, overflow byte absent");
    chk(n_adr == 1, "R5 address ack pulse", n_adr, 1);
    chk(n_done == 1, "R8 done pulse", n_done, 1);
    chk(fifo_level == '0, "R1 queue drained", int'(fifo_level), 0);

    // Park on an empty queue, then coincide a write with a pop.
    push(8'h52, 1'b0);
    push(8'h9A, 1'b0);
    ctl(0);
    idle_wait(400);
    chk(busy && scl_oe, "R6 parked with SCL low", int'({busy, scl_oe}), 3);
    chk(ev.size() == 3, "R6 no clocks while parked", ev.size(), 3);
    begin
      int held = 0;
      for (int i = 0; i < 100; i++) begin @(negedge clk); if (scl_oe) held++; end
      chk(held == 100, "R6 SCL held low every cycle", held, 100);
    end
    chk(ev.size() == 3, "R6 still no bus events", ev.size(), 3);
    wr_en = 1'b1; wr_data = 8'hC3;
    @(negedge clk);
    chk(fifo_level == LW'(1), "R7 level after first write", int'(fifo_level), 1);
    wr_data = 8'hD4;
    @(negedge clk);
    wr_en = 1'b0;
    chk(fifo_level == LW'(1), "R7 write and pop on one edge", int'(fifo_level), 1);
    ctl(1);
    idle_wait(400);
    chk(busy && scl_oe, "R10 parked after repeated start", int'({busy, scl_oe}), 3);
    push(8'h54, 1'b0);
    push(8'h11, 1'b0);
    ctl(2);
    wait_idle();
    expb(EV_START); expb(8'h52); expb(8'h9A); expb(8'hC3); expb(8'hD4);
    expb(EV_START); expb(8'h54); expb(8'h11); expb(EV_STOP);
    chk_ev("R7 R8 R10 restart sequence and byte order");
    chk(n_adr == 3, "R10 address ack after repeated start", n_adr, 3);
    chk(n_done == 3, "R8 done per request", n_done, 3);

    // Both requests in one cycle: stop wins.
    push(8'h30, 1'b0);
    push(8'h31, 1'b0);
    ctl(0);
    ctl(3);
    wait_idle();
    expb(EV_START); expb(8'h30); expb(8'h31); expb(EV_STOP);
    chk_ev("R9 stop outranks restart");
    chk(n_done == 4, "R9 single done", n_done, 4);

    // NACK on a data byte.
    nack_pos = 1;
    push(8'h60, 1'b0); push(8'h01, 1'b0); push(8'h02, 1'b0); push(8'h03, 1'b0);
    ctl(0);
    wait_idle();
    expb(EV_START); expb(8'h60); expb(8'h01); expb(EV_STOP);
    chk_ev("R11 data nack ends with stop");
    chk(n_nack == 1, "R11 nack pulse", n_nack, 1);
    chk(fifo_level == '0, "R11 queue flushed", int'(fifo_level), 0);
    chk(n_done == 4 && n_adr == 5, "R11 no done on nack", n_done, 4);

    // NACK on the address, with a stop request pending that must be dropped.
    nack_pos = 0;
    push(8'h70, 1'b0); push(8'h05, 1'b0);
    ctl(0);
    ctl(2);
    wait_idle();
    expb(EV_START); expb(8'h70); expb(EV_STOP);
    chk_ev("R11 address nack");
    chk(n_nack == 2 && n_adr == 5, "R5 R11 no address ack on nack", n_adr, 5);
    nack_pos = -1;
    push(8'h7E, 1'b0);
    ctl(0);
    idle_wait(300);
    chk(busy && scl_oe, "R11 requests cleared, engine parks", int'({busy, scl_oe}), 3);
    ctl(2);
    wait_idle();
    expb(EV_START); expb(8'h7E); expb(EV_STOP);
    chk_ev("R11 transfer after nack");
    chk(hbad == 0, "R4 SCL high phase width", hbad, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule